// File: doc/BRIEF.md
# Banked CPU Address Decoder

This block sits between an 8-bit CPU and the memories of a handheld-console memory map. Each cycle it takes a 16-bit address and a read or write strobe. It names the target of the access on a one-hot select, together with the local offset inside that target and the effective bank number. The external memories, the sound unit, the clock registers, the bank-controller registers and the I/O register file attach to one shared set of select, offset, bank and write-data lines. Each of them returns a byte on its own read-data lane.

Decoding is purely combinational. Read data is captured one clock after the read strobe by a registered multiplexer. Holes in the map produce a default byte in place of the memory data. The current bank values are inputs from the bank-controller logic, which is outside this block: the switchable ROM bank, the video RAM bank bit, the cartridge RAM bank, the work-RAM bank field, the cartridge RAM enable, the clock-select nibble and the controller flavour.

Top module: `mmap_router`

## Requirements
- R1: A read below 0x4000 selects fixed ROM (tgt_sel bit 0), bank 0. A read from 0x4000 to 0x7FFF selects switchable ROM (bit 1) with bank = rom_bank. Both use offset = addr & 0x3FFF.
- R2: A write below 0x8000 selects no ROM target. It selects the bank-controller port (bit 11) with offset = addr & 0x7FFF, tgt_we high and bank 0.
- R3: 0x8000–0x9FFF selects video RAM (bit 2) with bank = vram_bank and offset = addr & 0x1FFF.
- R4: 0xA000–0xBFFF with cram_en high and clk_sel[3] low selects cartridge RAM (bit 3), with bank = cram_bank and offset = addr & 0x1FFF. With cram_en low, nothing is selected and writes are dropped. A read then returns 0xFF, or 0x01 when alt_ctrl is high.
- R5: 0xA000–0xBFFF with cram_en high and clk_sel[3] high selects the clock registers (bit 4), with offset = clk_sel[2:0] and bank 0.
- R6: 0xC000–0xCFFF selects work RAM bank 0 (bit 5). 0xD000–0xDFFF selects banked work RAM (bit 6) with bank = wram_sel, except that wram_sel = 0 gives bank 1. Both use offset = addr & 0x0FFF.
- R7: Any access from 0xE000 to 0xFDFF decodes exactly as the address with bit 13 cleared.
- R8: 0xFE00–0xFE9F selects sprite attribute memory (bit 7) with offset = addr & 0xFF. 0xFEA0–0xFEFF selects nothing: writes are dropped and reads return 0xFF.
- R9: 0xFF10–0xFF3F selects sound (bit 8) with offset = addr & 0xFF. 0xFF80–0xFFFE selects high RAM (bit 9) with offset = addr & 0x7F. Every other 0xFFxx address, including 0xFFFF, selects the I/O register file (bit 10) with offset = addr & 0xFF.
- R10: A read cycle returns, at the next clock edge, the read-data lane of the selected target, or the default byte for a hole. cpu_rvalid is high for exactly the cycle after a read strobe. cpu_rdata holds its value when no read is taken.
- R11: tgt_sel has at most one bit set. It is all zero when neither strobe is high. When both strobes are high, the access is decoded and treated as a write, and no read data is returned.
- R12: Reset sets cpu_rvalid low and cpu_rdata to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| rom_bank | input | ROMB_W | Current switchable ROM bank |
| vram_bank | input | 1 | Video RAM bank bit |
| cram_bank | input | CRAMB_W | Cartridge RAM bank |
| wram_sel | input | 3 | Work-RAM bank field |
| cram_en | input | 1 | Cartridge RAM enabled |
| clk_sel | input | 4 | Clock-register select (bit 3 routes to clock registers) |
| alt_ctrl | input | 1 | Controller flavour whose disabled RAM reads as 0x01 |
| tgt_rdata | input | 12x8 | Per-target read-data lanes, indexed by tgt_sel bit |
| tgt_sel | output | 12 | One-hot target select |
| tgt_off | output | 15 | Local offset |
| tgt_bank | output | BANK_W | Effective bank number |
| tgt_we | output | 1 | Write enable to the selected target |
| tgt_wdata | output | 8 | Write data to the targets |
| cpu_rdata | output | 8 | Registered read data |
| cpu_rvalid | output | 1 | Read data valid |

## Verification
One cycle can hold two functions at once: the registered multiplexer returns the byte of the previous read while the decoder is already selecting the target of a new, unrelated access. The bench provokes this by issuing a work-RAM read and, on the very next cycle, a high-RAM write. In that second cycle it checks both the returned byte of the first access and the select, offset and write enable of the second. It also drives both strobes together and expects a write decode with no valid read data on the next cycle.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 16;
    localparam int OFF_W  = 15;
    localparam int NT     = 12;

    // Target index equals its bit position in the one-hot select.
    typedef enum logic [3:0] {
        T_ROM0  = 4'd0,
        T_ROMX  = 4'd1,
        T_VRAM  = 4'd2,
        T_CRAM  = 4'd3,
        T_CLKR  = 4'd4,
        T_WRAM0 = 4'd5,
        T_WRAMX = 4'd6,
        T_OAM   = 4'd7,
        T_SND   = 4'd8,
        T_HRAM  = 4'd9,
        T_IOREG = 4'd10,
        T_CTRL  = 4'd11,
        T_NONE  = 4'd15
    } tgt_e;

    typedef struct packed {
        tgt_e              tgt;
        logic [OFF_W-1:0]  off;
        logic              hole;
        logic [DATA_W-1:0] dflt;
    } dec_t;

    // Mirror region folds onto work RAM by dropping address bit 13.
    function automatic logic [ADDR_W-1:0] fold_echo(input logic [ADDR_W-1:0] a);
        if (a[15:13] == 3'b111 && a[15:9] != 7'h7F)
            return a & 16'hDFFF;
        return a;
    endfunction

    function automatic logic [2:0] wram_bank(input logic [2:0] f);
        return (f == 3'd0) ? 3'd1 : f;
    endfunction

endpackage

// File: rtl/mmap_region_decode.sv
module mmap_region_decode
    import mmap_pkg::*;
(
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic              cram_en,
    input  logic [3:0]        clk_sel,
    input  logic              alt_ctrl,
    output dec_t              dec
);

    logic [ADDR_W-1:0] ea;

    always_comb begin
        ea  = fold_echo(cpu_addr);
        dec = '{tgt: T_NONE, off: '0, hole: 1'b0, dflt: 8'hFF};
        if (cpu_rd | cpu_wr) begin
            if (!ea[15]) begin
                if (cpu_wr) begin
                    dec.tgt = T_CTRL;
                    dec.off = ea[14:0];
                end else begin
                    dec.tgt = ea[14] ? T_ROMX : T_ROM0;
                    dec.off = {1'b0, ea[13:0]};
                end
            end else begin
                unique case (ea[14:13])
                    2'b00: begin
                        dec.tgt = T_VRAM;
                        dec.off = {2'b0, ea[12:0]};
                    end
                    2'b01: begin
                        if (!cram_en) begin
                            dec.hole = 1'b1;
                            dec.dflt = alt_ctrl ? 8'h01 : 8'hFF;
                        end else if (clk_sel[3]) begin
                            dec.tgt = T_CLKR;
                            dec.off = {12'b0, clk_sel[2:0]};
                        end else begin
                            dec.tgt = T_CRAM;
                            dec.off = {2'b0, ea[12:0]};
                        end
                    end
                    2'b10: begin
                        dec.tgt = ea[12] ? T_WRAMX : T_WRAM0;
                        dec.off = {3'b0, ea[11:0]};
                    end
                    default: begin
                        if (!ea[8]) begin
                            if (ea[7:0] < 8'hA0) begin
                                dec.tgt = T_OAM;
                                dec.off = {7'b0, ea[7:0]};
                            end else begin
                                dec.hole = 1'b1;
                            end
                        end else if (ea[7:0] >= 8'h10 && ea[7:0] <= 8'h3F) begin
                            dec.tgt = T_SND;
                            dec.off = {7'b0, ea[7:0]};
                        end else if (ea[7] && ea[7:0] != 8'hFF) begin
                            dec.tgt = T_HRAM;
                            dec.off = {8'b0, ea[6:0]};
                        end else begin
                            dec.tgt = T_IOREG;
                            dec.off = {7'b0, ea[7:0]};
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/mmap_bank_resolve.sv
module mmap_bank_resolve
    import mmap_pkg::*;
#(
    parameter int ROMB_W  = 9,
    parameter int CRAMB_W = 4,
    parameter int BANK_W  = 9
) (
    input  tgt_e               tgt,
    input  logic [ROMB_W-1:0]  rom_bank,
    input  logic               vram_bank,
    input  logic [CRAMB_W-1:0] cram_bank,
    input  logic [2:0]         wram_sel,
    output logic [BANK_W-1:0]  bank
);

    always_comb begin
        unique case (tgt)
            T_ROMX:  bank = BANK_W'(rom_bank);
            T_VRAM:  bank = BANK_W'(vram_bank);
            T_CRAM:  bank = BANK_W'(cram_bank);
            T_WRAMX: bank = BANK_W'(wram_bank(wram_sel));
            default: bank = '0;
        endcase
    end

endmodule

// File: rtl/mmap_rdata_reg.sv
module mmap_rdata_reg
    import mmap_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rd_go,
    input  logic [NT-1:0]            sel,
    input  logic                     hole,
    input  logic [DATA_W-1:0]        dflt,
    input  logic [NT-1:0][DATA_W-1:0] lanes,
    output logic [DATA_W-1:0]        rdata,
    output logic                     rvalid
);

    logic [NT-1:0][DATA_W-1:0] term;
    logic [DATA_W-1:0]         pick;

    for (genvar i = 0; i < NT; i++) begin : g_lane
        assign term[i] = {DATA_W{sel[i]}} & lanes[i];
    end

    always_comb begin
        pick = '0;
        for (int i = 0; i < NT; i++)
            pick = pick | term[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= 8'hFF;
        end else begin
            rvalid <= rd_go;
            if (rd_go)
                rdata <= hole ? dflt : pick;
        end
    end

endmodule

// File: rtl/mmap_router.sv
module mmap_router
    import mmap_pkg::*;
#(
    parameter int ROMB_W  = 9,
    parameter int CRAMB_W = 4,
    localparam int BANK_W = (ROMB_W > CRAMB_W) ? ((ROMB_W > 3) ? ROMB_W : 3)
                                               : ((CRAMB_W > 3) ? CRAMB_W : 3)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [15:0]               cpu_addr,
    input  logic                      cpu_rd,
    input  logic                      cpu_wr,
    input  logic [7:0]                cpu_wdata,
    input  logic [ROMB_W-1:0]         rom_bank,
    input  logic                      vram_bank,
    input  logic [CRAMB_W-1:0]        cram_bank,
    input  logic [2:0]                wram_sel,
    input  logic                      cram_en,
    input  logic [3:0]                clk_sel,
    input  logic                      alt_ctrl,
    input  logic [11:0][7:0]          tgt_rdata,
    output logic [11:0]               tgt_sel,
    output logic [14:0]               tgt_off,
    output logic [BANK_W-1:0]         tgt_bank,
    output logic                      tgt_we,
    output logic [7:0]                tgt_wdata,
    output logic [7:0]                cpu_rdata,
    output logic                      cpu_rvalid
);

    dec_t dec;
    logic rd_go;

    mmap_region_decode u_dec (
        .cpu_addr (cpu_addr),
        .cpu_rd   (cpu_rd),
        .cpu_wr   (cpu_wr),
        .cram_en  (cram_en),
        .clk_sel  (clk_sel),
        .alt_ctrl (alt_ctrl),
        .dec      (dec)
    );

    mmap_bank_resolve #(
        .ROMB_W  (ROMB_W),
        .CRAMB_W (CRAMB_W),
        .BANK_W  (BANK_W)
    ) u_bank (
        .tgt       (dec.tgt),
        .rom_bank  (rom_bank),
        .vram_bank (vram_bank),
        .cram_bank (cram_bank),
        .wram_sel  (wram_sel),
        .bank      (tgt_bank)
    );

    for (genvar i = 0; i < NT; i++) begin : g_sel
        assign tgt_sel[i] = (4'(dec.tgt) == 4'(i));
    end

    assign tgt_off   = dec.off;
    assign tgt_we    = cpu_wr & (|tgt_sel);
    assign tgt_wdata = cpu_wdata;
    assign rd_go     = cpu_rd & ~cpu_wr;

    mmap_rdata_reg u_rdq (
        .clk    (clk),
        .rst    (rst),
        .rd_go  (rd_go),
        .sel    (tgt_sel),
        .hole   (dec.hole),
        .dflt   (dec.dflt),
        .lanes  (tgt_rdata),
        .rdata  (cpu_rdata),
        .rvalid (cpu_rvalid)
    );

endmodule

// File: rtl/mmap_router_chk.sv
module mmap_router_chk #(
    parameter int BANK_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic [15:0]       cpu_addr,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic              cram_en,
    input logic              alt_ctrl,
    input logic [11:0]       tgt_sel,
    input logic [BANK_W-1:0] tgt_bank,
    input logic              tgt_we,
    input logic [7:0]        cpu_rdata,
    input logic              cpu_rvalid
);

    p_onehot_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tgt_sel));

    p_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (!cpu_rd && !cpu_wr) |-> (tgt_sel == 12'h000));

    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && !cpu_addr[15]) |-> (tgt_sel == 12'h800 && tgt_we));

    p_rvalid_r10: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && !cpu_wr) |=> cpu_rvalid);

    p_no_rvalid_r10: assert property (@(posedge clk) disable iff (rst)
        !(cpu_rd && !cpu_wr) |=> !cpu_rvalid);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(cpu_rd && !cpu_wr) |=> $stable(cpu_rdata));

    p_wram_bank_r6: assert property (@(posedge clk) disable iff (rst)
        tgt_sel[6] |-> (tgt_bank != '0));

    p_oam_hole_r8: assert property (@(posedge clk) disable iff (rst)
        ((cpu_rd || cpu_wr) && cpu_addr[15:8] == 8'hFE && cpu_addr[7:0] >= 8'hA0)
        |-> (tgt_sel == 12'h000));

    p_cram_off_r4: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && !cpu_wr && cpu_addr[15:13] == 3'b101 && !cram_en && !alt_ctrl)
        |=> (cpu_rdata == 8'hFF));

endmodule

bind mmap_router mmap_router_chk #(.BANK_W(BANK_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_addr   (cpu_addr),
    .cpu_rd     (cpu_rd),
    .cpu_wr     (cpu_wr),
    .cram_en    (cram_en),
    .alt_ctrl   (alt_ctrl),
    .tgt_sel    (tgt_sel),
    .tgt_bank   (tgt_bank),
    .tgt_we     (tgt_we),
    .cpu_rdata  (cpu_rdata),
    .cpu_rvalid (cpu_rvalid)
);

// File: tb/mmap_router_bench.sv
module mmap_router_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic        cpu_rd, cpu_wr;
    logic [7:0]  cpu_wdata;
    logic [8:0]  rom_bank;
    logic        vram_bank;
    logic [3:0]  cram_bank;
    logic [2:0]  wram_sel;
    logic        cram_en;
    logic [3:0]  clk_sel;
    logic        alt_ctrl;
    logic [11:0][7:0] tgt_rdata;
    logic [11:0] tgt_sel;
    logic [14:0] tgt_off;
    logic [8:0]  tgt_bank;
    logic        tgt_we;
    logic [7:0]  tgt_wdata;
    logic [7:0]  cpu_rdata;
    logic        cpu_rvalid;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    mmap_router u_mmap_router (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .rom_bank(rom_bank), .vram_bank(vram_bank),
        .cram_bank(cram_bank), .wram_sel(wram_sel), .cram_en(cram_en),
        .clk_sel(clk_sel), .alt_ctrl(alt_ctrl), .tgt_rdata(tgt_rdata),
        .tgt_sel(tgt_sel), .tgt_off(tgt_off), .tgt_bank(tgt_bank), .tgt_we(tgt_we),
        .tgt_wdata(tgt_wdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Reference decode written from the requirements.
    task automatic ref_decode(input logic [15:0] a, input bit wr,
                              output int idx, output int off, output int bank,
                              output int dflt);
        logic [15:0] e;
        e = (a >= 16'hE000 && a < 16'hFE00) ? (a & 16'hDFFF) : a;
        idx = -1; off = 0; bank = 0; dflt = 8'hFF;
        if (e < 16'h8000) begin
            if (wr) begin idx = 11; off = e & 16'h7FFF; end
            else if (e < 16'h4000) begin idx = 0; off = e & 16'h3FFF; end
            else begin idx = 1; off = e & 16'h3FFF; bank = rom_bank; end
        end else if (e < 16'hA000) begin
            idx = 2; off = e & 16'h1FFF; bank = vram_bank;
        end else if (e < 16'hC000) begin
            if (!cram_en) dflt = alt_ctrl ? 8'h01 : 8'hFF;
            else if (clk_sel[3]) begin idx = 4; off = clk_sel[2:0]; end
            else begin idx = 3; off = e & 16'h1FFF; bank = cram_bank; end
        end else if (e < 16'hD000) begin
            idx = 5; off = e & 16'h0FFF;
        end else if (e < 16'hE000) begin
            idx = 6; off = e & 16'h0FFF; bank = (wram_sel == 0) ? 1 : wram_sel;
        end else if (e < 16'hFEA0) begin
            idx = 7; off = e & 16'hFF;
        end else if (e < 16'hFF00) begin
            idx = -1;
        end else if (e >= 16'hFF10 && e <= 16'hFF3F) begin
            idx = 8; off = e & 16'hFF;
        end else if (e >= 16'hFF80 && e <= 16'hFFFE) begin
            idx = 9; off = e & 16'h7F;
        end else begin
            idx = 10; off = e & 16'hFF;
        end
    endtask

    task automatic probe(input string tag, input logic [15:0] a, input bit rd, input bit wr);
        int idx, off, bank, dflt;
        ref_decode(a, wr, idx, off, bank, dflt);
        @(negedge clk);
        cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = 8'h3C;
        #2;
        chk(tag, "sel", int'(tgt_sel), (idx < 0) ? 0 : (1 << idx));
        if (idx >= 0) begin
            chk(tag, "off", int'(tgt_off), off);
            chk(tag, "bank", int'(tgt_bank), bank);
        end
        chk(tag, "we", int'(tgt_we), int'(wr && idx >= 0));
        @(negedge clk);
        cpu_rd = 0; cpu_wr = 0;
        #1;
        chk(tag, "rvalid", int'(cpu_rvalid), int'(rd && !wr));
        if (rd && !wr)
            chk(tag, "rdata", int'(cpu_rdata), (idx < 0) ? dflt : (8'hA0 + idx));
    endtask

    task automatic t_reset;
        #1;
        chk("R12", "rvalid", int'(cpu_rvalid), 0);
        chk("R12", "rdata", int'(cpu_rdata), 8'hFF);
        chk("R11", "idle sel", int'(tgt_sel), 0);
    endtask

    task automatic t_rom;
        probe("R1", 16'h0123, 1, 0);
        probe("R1", 16'h3FFF, 1, 0);
        probe("R1", 16'h4000, 1, 0);
        rom_bank = 9'h1A5;
        probe("R1", 16'h7ABC, 1, 0);
    endtask

    task automatic t_ctrl;
        probe("R2", 16'h2100, 0, 1);
        probe("R2", 16'h6001, 0, 1);
    endtask

    task automatic t_vram;
        vram_bank = 0; probe("R3", 16'h8001, 1, 0);
        vram_bank = 1; probe("R3", 16'h9FFF, 0, 1);
    endtask

    task automatic t_cram;
        cram_en = 0; alt_ctrl = 0; probe("R4", 16'hA010, 1, 0);
        alt_ctrl = 1;              probe("R4", 16'hB000, 1, 0);
        probe("R4", 16'hA020, 0, 1);
        alt_ctrl = 0; cram_en = 1; clk_sel = 4'h3; cram_bank = 4'h9;
        probe("R4", 16'hBFFE, 1, 0);
        clk_sel = 4'hD; probe("R5", 16'hA000, 1, 0);
        clk_sel = 4'h8; probe("R5", 16'hB123, 0, 1);
        clk_sel = 4'h0;
    endtask

    task automatic t_wram;
        probe("R6", 16'hC456, 1, 0);
        wram_sel = 3'd0; probe("R6", 16'hD010, 1, 0);
        wram_sel = 3'd5; probe("R6", 16'hDFFF, 0, 1);
        wram_sel = 3'd7; probe("R6", 16'hD800, 1, 0);
    endtask

    task automatic t_echo;
        probe("R7", 16'hE123, 1, 0);
        wram_sel = 3'd0; probe("R7", 16'hF456, 1, 0);
        wram_sel = 3'd3; probe("R7", 16'hFDFF, 0, 1);
    endtask

    task automatic t_oam;
        probe("R8", 16'hFE00, 1, 0);
        probe("R8", 16'hFE9F, 0, 1);
        probe("R8", 16'hFEA0, 1, 0);
        probe("R8", 16'hFEFF, 0, 1);
    endtask

    task automatic t_high;
        probe("R9", 16'hFF10, 1, 0);
        probe("R9", 16'hFF3F, 0, 1);
        probe("R9", 16'hFF0F, 1, 0);
        probe("R9", 16'hFF40, 1, 0);
        probe("R9", 16'hFF80, 1, 0);
        probe("R9", 16'hFFFE, 0, 1);
        probe("R9", 16'hFFFF, 1, 0);
    endtask

    task automatic t_both;
        probe("R11", 16'hC010, 1, 1);
        probe("R11", 16'h1000, 1, 1);
    endtask

    // Read returns while the next cycle decodes an unrelated write.
    task automatic t_overlap;
        @(negedge clk);
        cpu_addr = 16'hC010; cpu_rd = 1; cpu_wr = 0;
        @(negedge clk);
        cpu_addr = 16'hFF90; cpu_rd = 0; cpu_wr = 1;
        #2;
        chk("R10", "rvalid during write", int'(cpu_rvalid), 1);
        chk("R10", "rdata during write", int'(cpu_rdata), 8'hA5);
        chk("R9", "sel during return", int'(tgt_sel), 1 << 9);
        chk("R9", "off during return", int'(tgt_off), 8'h10);
        chk("R2", "we during return", int'(tgt_we), 1);
        @(negedge clk);
        cpu_wr = 0;
        #1;
        chk("R10", "rvalid after write", int'(cpu_rvalid), 0);
        chk("R10", "rdata held", int'(cpu_rdata), 8'hA5);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 12; i++) tgt_rdata[i] = 8'(8'hA0 + i);
        cpu_addr = 16'h0; cpu_rd = 0; cpu_wr = 0; cpu_wdata = 0;
        rom_bank = 9'h005; vram_bank = 0; cram_bank = 4'h2; wram_sel = 3'd0;
        cram_en = 1; clk_sel = 4'h0; alt_ctrl = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset;
        t_rom;
        t_ctrl;
        t_vram;
        t_cram;
        t_wram;
        t_echo;
        t_oam;
        t_high;
        t_both;
        t_overlap;
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule